// File: doc/BRIEF.md
# MDIO Management Responder

This block is the device side of a two-wire management link. It watches the management clock and the shared data line, and it decodes register-access frames of the 5-bit-address kind. It serves a bank of 32 registers of 16 bits each. A master starts every frame with a run of ones. Then it sends a start pattern, an opcode, a 5-bit device address, a 5-bit register address, a two-bit turnaround and a 16-bit data word.

The block answers to a local device address, which is taken from strap pins while reset is held. It also answers to the all-zero address, which acts as a broadcast. For a read, it takes over the shared line in the middle of the turnaround and returns the addressed register, most significant bit first. For a write, it shifts in the data word and commits it to the bank only after the last bit has arrived. It also passes the write to local logic as a one-cycle strobe with the register address and data.

Both the management clock and the data line are sampled with the block's system clock, which must run several times faster than the management clock. A pause in the management clock longer than a set number of system clocks abandons any frame in progress.

Top module: `mdio_responder`

## Requirements
- R1: A frame is recognised only after at least 32 consecutive sampled ones followed by a 0 then a 1. Fewer than 32 ones before the 0 causes the frame to be ignored. A longer run of ones is accepted.
- R2: Opcode bits 01 (first bit 0) mark a write. The master then sends turnaround bits 1,0 and 16 data bits, most significant first. These are stored in the register selected by the 5-bit register address, and `regWrStb` pulses for exactly one clock with that address and data.
- R3: Opcode bits 10 mark a read. The line is left released for the first turnaround bit and driven to 0 for the second. The 16 bits of the addressed register then follow, most significant first.
- R4: The local device address is the value on `strapAddr` while `rstN` is low. Changes on `strapAddr` after reset is released have no effect on address matching.
- R5: A frame whose device address is neither the local address nor 0 never drives the line and never writes a register.
- R6: Device address 0 is accepted for both writes and reads.
- R7: Opcodes 00 and 11 abort the frame, with no drive and no write, and the block goes back to hunting for a preamble.
- R8: If the management clock stops for more than 64 system clocks before the 16th data bit of a write, the frame is abandoned and nothing is written. The next full frame is served normally.
- R9: The driven value and the output enable change only in response to a rising management clock edge. The output enable drops after the last data bit of a read.
- R10: After reset the output enable is low, no write strobe has occurred, and every register reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the management clock and data line |
| rstN | input | 1 | Active-low synchronous reset; the strap address is captured while it is low |
| strapAddr | input | 5 | Strap value that gives the local device address |
| mdc | input | 1 | Management clock from the master |
| mdioIn | input | 1 | Sampled value of the shared data line |
| mdioOut | output | 1 | Value driven onto the shared data line when enabled |
| mdioOe | output | 1 | Output enable for the shared data line |
| regWrStb | output | 1 | One-cycle pulse on each committed write |
| regWrAddr | output | 5 | Register address of the committed write |
| regWrData | output | 16 | Data of the committed write |

## Verification
The hardest situations to reach from the ports are the edges of frame recognition: a preamble exactly one bit short, an illegal opcode, and a write cut off mid-word that must not commit even when later bits arrive. The stimulus builds each frame bit by bit from master tasks. These tasks can shorten the preamble, substitute any opcode, or stop the clock after a chosen number of data bits. A later full frame or a readback then shows through the normal read path that no register changed. Random frames aimed at the local address, the broadcast address and foreign addresses are checked against a register shadow kept in the bench.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

  typedef enum logic [2:0] {
    ST_HUNT,
    ST_START,
    ST_OP,
    ST_ADDR,
    ST_TA,
    ST_DATA
  } mdioState_t;

  // strobes from the frame controller to the register datapath
  typedef struct packed {
    logic hdrShift;   // shift one address bit in
    logic dataIn;     // shift one write-data bit in
    logic readLoad;   // load the read shifter from the bank
    logic readShift;  // advance the read shifter
    logic commit;     // last write bit arrives now
    logic bitVal;     // sampled line value for this edge
  } dpCmd_t;

endpackage

// File: rtl/mdio_ctrl.sv
module mdio_ctrl
  import mdio_pkg::*;
#(
  parameter int PRE_LEN    = 32,
  parameter int ADDR_W     = 5,
  parameter int DATA_W     = 16,
  parameter int IDLE_LIMIT = 64
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   mdc,
  input  logic   mdioIn,
  input  logic   addrHit,
  input  logic   topBit,
  output dpCmd_t cmd,
  output logic   mdioOut,
  output logic   mdioOe
);

  localparam int HDR_LEN = 2 * ADDR_W;
  localparam int CNT_MAX = (HDR_LEN > DATA_W) ? HDR_LEN : DATA_W;
  localparam int CNT_W   = $clog2(CNT_MAX);
  localparam int PRE_W   = $clog2(PRE_LEN + 1);
  localparam int IDLE_W  = $clog2(IDLE_LIMIT + 1);

  logic [2:0] mdcSh;
  logic [1:0] mdioSh;
  logic       bitStb;
  logic       bitVal;

  mdioState_t        state;
  logic [PRE_W-1:0]  ones;
  logic [CNT_W-1:0]  cnt;
  logic              opHi;
  logic              isRead;
  logic [IDLE_W-1:0] idleCnt;
  logic              timeout;

  // two-stage synchroniser plus edge history
  always_ff @(posedge clk) begin
    if (!rstN) begin
      mdcSh  <= '0;
      mdioSh <= '1;
    end else begin
      mdcSh  <= {mdcSh[1:0], mdc};
      mdioSh <= {mdioSh[0], mdioIn};
    end
  end

  assign bitStb  = mdcSh[1] & ~mdcSh[2];
  assign bitVal  = mdioSh[1];
  assign timeout = !bitStb && (idleCnt == IDLE_W'(IDLE_LIMIT - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idleCnt <= '0;
    end else if (bitStb) begin
      idleCnt <= '0;
    end else if (idleCnt != IDLE_W'(IDLE_LIMIT)) begin
      idleCnt <= idleCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_HUNT;
      ones   <= '0;
      cnt    <= '0;
      opHi   <= 1'b0;
      isRead <= 1'b0;
      mdioOe <= 1'b0;
    end else if (bitStb) begin
      case (state)
        ST_HUNT: begin
          if (bitVal) begin
            if (ones != PRE_W'(PRE_LEN)) ones <= ones + 1'b1;
          end else if (ones == PRE_W'(PRE_LEN)) begin
            state <= ST_START;
          end else begin
            ones <= '0;
          end
        end
        ST_START: begin
          ones <= '0;
          cnt  <= '0;
          state <= bitVal ? ST_OP : ST_HUNT;
        end
        ST_OP: begin
          if (cnt == '0) begin
            opHi <= bitVal;
            cnt  <= CNT_W'(1);
          end else begin
            cnt <= '0;
            if ({opHi, bitVal} == 2'b10) begin
              isRead <= 1'b1;
              state  <= ST_ADDR;
            end else if ({opHi, bitVal} == 2'b01) begin
              isRead <= 1'b0;
              state  <= ST_ADDR;
            end else begin
              state <= ST_HUNT;
            end
          end
        end
        ST_ADDR: begin
          if (cnt == CNT_W'(HDR_LEN - 1)) begin
            cnt   <= '0;
            state <= ST_TA;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_TA: begin
          if (cnt == '0) begin
            if (!addrHit) begin
              state <= ST_HUNT;
            end else begin
              cnt <= CNT_W'(1);
              if (isRead) mdioOe <= 1'b1;
            end
          end else begin
            cnt   <= '0;
            state <= ST_DATA;
          end
        end
        ST_DATA: begin
          if (cnt == CNT_W'(DATA_W - 1)) begin
            cnt    <= '0;
            mdioOe <= 1'b0;
            state  <= ST_HUNT;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= ST_HUNT;
      endcase
    end else if (timeout) begin
      state  <= ST_HUNT;
      ones   <= '0;
      cnt    <= '0;
      mdioOe <= 1'b0;
    end
  end

  always_comb begin
    cmd        = '0;
    cmd.bitVal = bitVal;
    if (bitStb) begin
      cmd.hdrShift  = (state == ST_ADDR);
      cmd.dataIn    = (state == ST_DATA) && !isRead;
      cmd.readShift = (state == ST_DATA) && isRead;
      cmd.readLoad  = (state == ST_TA) && (cnt == '0) && isRead && addrHit;
      cmd.commit    = (state == ST_DATA) && !isRead && (cnt == CNT_W'(DATA_W - 1));
    end
  end

  assign mdioOut = mdioOe && (state == ST_DATA) && topBit;

  // R9: the bus is taken only in response to a sampled rising edge
  a_r9_oe_rise_on_edge: assert property (@(posedge clk) disable iff (!rstN)
    $rose(mdioOe) |-> $past(bitStb));

  // R9: while driving, the driven value moves only after an edge
  a_r9_out_moves_on_edge: assert property (@(posedge clk) disable iff (!rstN)
    (mdioOe && $past(mdioOe) && !$stable(mdioOut)) |-> $past(bitStb));

  // R3: the first driven bit of a read is the turnaround zero
  a_r3_ta_zero_first: assert property (@(posedge clk) disable iff (!rstN)
    $rose(mdioOe) |-> !mdioOut);

  // R2: a write commit never coincides with driving the line
  a_r2_commit_not_driving: assert property (@(posedge clk) disable iff (!rstN)
    cmd.commit |-> !mdioOe);

endmodule

// File: rtl/mdio_regbank.sv
module mdio_regbank
  import mdio_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] strapAddr,
  input  dpCmd_t            cmd,
  output logic              addrHit,
  output logic              topBit,
  output logic              regWrStb,
  output logic [ADDR_W-1:0] regWrAddr,
  output logic [DATA_W-1:0] regWrData
);

  localparam int HDR_LEN  = 2 * ADDR_W;
  localparam int NUM_REGS = 1 << ADDR_W;

  logic [ADDR_W-1:0]  portAddr;
  logic [HDR_LEN-1:0] hdr;
  logic [ADDR_W-1:0]  phyField;
  logic [ADDR_W-1:0]  regField;
  logic [DATA_W-1:0]  dataShift;
  logic [DATA_W-1:0]  wrWord;
  logic [DATA_W-1:0]  bank [NUM_REGS];

  // local address follows the straps only while reset is held
  always_ff @(posedge clk) begin
    if (!rstN) portAddr <= strapAddr;
  end

  always_ff @(posedge clk) begin
    if (!rstN)             hdr <= '0;
    else if (cmd.hdrShift) hdr <= {hdr[HDR_LEN-2:0], cmd.bitVal};
  end

  assign phyField = hdr[HDR_LEN-1 -: ADDR_W];
  assign regField = hdr[ADDR_W-1:0];
  assign addrHit  = (phyField == portAddr) || (phyField == '0);
  assign wrWord   = {dataShift[DATA_W-2:0], cmd.bitVal};
  assign topBit   = dataShift[DATA_W-1];

  always_ff @(posedge clk) begin
    if (!rstN)              dataShift <= '0;
    else if (cmd.readLoad)  dataShift <= bank[regField];
    else if (cmd.readShift) dataShift <= {dataShift[DATA_W-2:0], 1'b0};
    else if (cmd.dataIn)    dataShift <= wrWord;
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : gReg
    always_ff @(posedge clk) begin
      if (!rstN)
        bank[g] <= '0;
      else if (cmd.commit && (regField == ADDR_W'(g)))
        bank[g] <= wrWord;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      regWrStb  <= 1'b0;
      regWrAddr <= '0;
      regWrData <= '0;
    end else begin
      regWrStb <= cmd.commit;
      if (cmd.commit) begin
        regWrAddr <= regField;
        regWrData <= wrWord;
      end
    end
  end

  // R4: the strap-derived address stays put once reset is released
  a_r4_strap_held: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> $stable(portAddr));

  // R2: each committed write gives a single-cycle strobe
  a_r2_single_strobe: assert property (@(posedge clk) disable iff (!rstN)
    regWrStb |=> !regWrStb);

  // R2: the address field is frozen while write data streams in
  a_r2_hdr_frozen: assert property (@(posedge clk) disable iff (!rstN)
    cmd.dataIn |-> !cmd.hdrShift);

endmodule

// File: rtl/mdio_responder.sv
module mdio_responder
  import mdio_pkg::*;
#(
  parameter int PRE_LEN    = 32,
  parameter int ADDR_W     = 5,
  parameter int DATA_W     = 16,
  parameter int IDLE_LIMIT = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] strapAddr,
  input  logic              mdc,
  input  logic              mdioIn,
  output logic              mdioOut,
  output logic              mdioOe,
  output logic              regWrStb,
  output logic [ADDR_W-1:0] regWrAddr,
  output logic [DATA_W-1:0] regWrData
);

  dpCmd_t cmd;
  logic   addrHit;
  logic   topBit;

  mdio_ctrl #(
    .PRE_LEN(PRE_LEN), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDLE_LIMIT(IDLE_LIMIT)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .mdc(mdc), .mdioIn(mdioIn),
    .addrHit(addrHit), .topBit(topBit), .cmd(cmd),
    .mdioOut(mdioOut), .mdioOe(mdioOe)
  );

  mdio_regbank #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_bank (
    .clk(clk), .rstN(rstN), .strapAddr(strapAddr), .cmd(cmd),
    .addrHit(addrHit), .topBit(topBit), .regWrStb(regWrStb),
    .regWrAddr(regWrAddr), .regWrData(regWrData)
  );

  // R5: the line is driven only for an accepted address
  a_r5_drive_needs_match: assert property (@(posedge clk) disable iff (!rstN)
    mdioOe |-> addrHit);

  // R5: a write strobe follows only an accepted address
  a_r5_write_needs_match: assert property (@(posedge clk) disable iff (!rstN)
    cmd.commit |-> addrHit);

endmodule

// File: tb/sim_mdio_responder.sv
module sim_mdio_responder;

  localparam logic [4:0] LOCAL_ADDR = 5'd9;

  logic        clk = 1'b0;
  logic        rstN;
  logic [4:0]  strapAddr;
  logic        mdc;
  logic        mstDrv;
  logic        mstVal;
  logic        mdioBus;
  logic        mdioOut;
  logic        mdioOe;
  logic        regWrStb;
  logic [4:0]  regWrAddr;
  logic [15:0] regWrData;

  int nChecks = 0;
  int nFails  = 0;
  int strobeCnt = 0;
  int oeCycles  = 0;
  logic [4:0]  lastAddr;
  logic [15:0] lastData;
  logic [15:0] model [32];

  always #4 clk = ~clk;

  assign mdioBus = mdioOe ? mdioOut : (mstDrv ? mstVal : 1'b1);

  mdio_responder u0 (
    .clk(clk), .rstN(rstN), .strapAddr(strapAddr), .mdc(mdc), .mdioIn(mdioBus),
    .mdioOut(mdioOut), .mdioOe(mdioOe), .regWrStb(regWrStb),
    .regWrAddr(regWrAddr), .regWrData(regWrData)
  );

  always @(posedge clk) begin
    if (regWrStb) begin
      strobeCnt <= strobeCnt + 1;
      lastAddr  <= regWrAddr;
      lastData  <= regWrData;
    end
    if (mdioOe) oeCycles <= oeCycles + 1;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: act=hung exp=finished");
    $display("  %0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bitOut(input logic b);
    mstDrv = 1'b1;
    mstVal = b;
    tick(4);
    mdc = 1'b1;
    tick(4);
    mdc = 1'b0;
  endtask

  task automatic bitIn(output logic v, output logic oe);
    mstDrv = 1'b0;
    tick(4);
    v  = mdioBus;
    oe = mdioOe;
    mdc = 1'b1;
    tick(4);
    mdc = 1'b0;
  endtask

  task automatic sendHdr(input int pre, input logic [1:0] op, input logic [4:0] phy,
                         input logic [4:0] rg);
    for (int i = 0; i < pre; i++) bitOut(1'b1);
    bitOut(1'b0);
    bitOut(1'b1);
    bitOut(op[1]);
    bitOut(op[0]);
    for (int i = 4; i >= 0; i--) bitOut(phy[i]);
    for (int i = 4; i >= 0; i--) bitOut(rg[i]);
  endtask

  // master-driven frame: writes, or any frame with a bad opcode
  task automatic doWrite(input logic [1:0] op, input logic [4:0] phy, input logic [4:0] rg,
                         input logic [15:0] d, input int pre, input int nBits);
    sendHdr(pre, op, phy, rg);
    bitOut(1'b1);
    bitOut(1'b0);
    for (int i = 0; i < nBits; i++) bitOut(d[15-i]);
    mstDrv = 1'b0;
    tick(80);
  endtask

  task automatic doRead(input logic [4:0] phy, input logic [4:0] rg, output logic [15:0] d,
                        output logic ta1Oe, output logic ta2Oe, output logic ta2Val,
                        output logic endOe);
    logic v;
    logic oe;
    sendHdr(32, 2'b10, phy, rg);
    bitIn(v, ta1Oe);
    bitIn(ta2Val, ta2Oe);
    for (int i = 15; i >= 0; i--) begin
      bitIn(v, oe);
      d[i] = v;
    end
    bitIn(v, endOe);
    tick(80);
  endtask

  function automatic logic accepts(input logic [4:0] phy);
    return (phy == LOCAL_ADDR) || (phy == 5'd0);
  endfunction

  initial begin
    logic [15:0] rd;
    logic ta1Oe, ta2Oe, ta2Val, endOe;
    int s0, o0;
    void'($urandom(32'h5eed1));
    for (int i = 0; i < 32; i++) model[i] = 16'h0;
    rstN = 1'b0; strapAddr = LOCAL_ADDR; mdc = 1'b0; mstDrv = 1'b0; mstVal = 1'b1;
    tick(10);
    rstN = 1'b1;
    tick(5);
    strapAddr = 5'd3;   // R4: later strap moves must not matter

    // R10: reset state
    chk("R10 oe after reset", {31'b0, mdioOe}, 32'd0);
    chk("R10 no strobe after reset", strobeCnt, 0);
    doRead(LOCAL_ADDR, 5'd7, rd, ta1Oe, ta2Oe, ta2Val, endOe);
    chk("R10 register reset value", rd, 32'h0);
    // R3 / R9: turnaround handling and release
    chk("R3 first TA bit released", {31'b0, ta1Oe}, 32'd0);
    chk("R3 second TA bit driven", {31'b0, ta2Oe}, 32'd1);
    chk("R3 second TA bit is zero", {31'b0, ta2Val}, 32'd0);
    chk("R9 released after last bit", {31'b0, endOe}, 32'd0);

    // R2: directed write then readback
    s0 = strobeCnt;
    doWrite(2'b01, LOCAL_ADDR, 5'd4, 16'hA5C3, 32, 16);
    chk("R2 one strobe", strobeCnt - s0, 1);
    chk("R2 strobe address", lastAddr, 32'd4);
    chk("R2 strobe data", lastData, 32'hA5C3);
    model[4] = 16'hA5C3;
    doRead(LOCAL_ADDR, 5'd4, rd, ta1Oe, ta2Oe, ta2Val, endOe);
    chk("R3 readback", rd, 32'hA5C3);

    // R4: new strap value is not the local address
    s0 = strobeCnt;
    doWrite(2'b01, 5'd3, 5'd4, 16'h1111, 32, 16);
    chk("R4 late strap ignored", strobeCnt - s0, 0);
    doRead(LOCAL_ADDR, 5'd4, rd, ta1Oe, ta2Oe, ta2Val, endOe);
    chk("R4 local address still served", rd, 32'hA5C3);

    // R5: foreign address
    s0 = strobeCnt; o0 = oeCycles;
    doWrite(2'b01, 5'd17, 5'd4, 16'h2222, 32, 16);
    doRead(5'd17, 5'd4, rd, ta1Oe, ta2Oe, ta2Val, endOe);
    chk("R5 no write for foreign address", strobeCnt - s0, 0);
    chk("R5 no drive for foreign address", oeCycles - o0, 0);

    // R6: broadcast write and read
    s0 = strobeCnt;
    doWrite(2'b01, 5'd0, 5'd31, 16'hFFFF, 32, 16);
    chk("R6 broadcast write strobe", strobeCnt - s0, 1);
    model[31] = 16'hFFFF;
    doRead(5'd0, 5'd31, rd, ta1Oe, ta2Oe, ta2Val, endOe);
    chk("R6 broadcast read data", rd, 32'hFFFF);
    chk("R6 broadcast read TA zero", {31'b0, ta2Val}, 32'd0);

    // R1: preamble one bit short, then an over-long preamble
    s0 = strobeCnt;
    doWrite(2'b01, LOCAL_ADDR, 5'd2, 16'h1234, 31, 16);
    chk("R1 short preamble ignored", strobeCnt - s0, 0);
    doRead(LOCAL_ADDR, 5'd2, rd, ta1Oe, ta2Oe, ta2Val, endOe);
    chk("R1 register untouched", rd, 32'h0);
    doWrite(2'b01, LOCAL_ADDR, 5'd2, 16'h1234, 45, 16);
    chk("R1 long preamble accepted", strobeCnt - s0, 1);
    model[2] = 16'h1234;

    // R7: illegal opcodes
    s0 = strobeCnt; o0 = oeCycles;
    doWrite(2'b11, LOCAL_ADDR, 5'd2, 16'h5555, 32, 16);
    doWrite(2'b00, LOCAL_ADDR, 5'd2, 16'hAAAA, 32, 16);
    chk("R7 no write on bad opcode", strobeCnt - s0, 0);
    chk("R7 no drive on bad opcode", oeCycles - o0, 0);
    doRead(LOCAL_ADDR, 5'd2, rd, ta1Oe, ta2Oe, ta2Val, endOe);
    chk("R7 register unchanged", rd, 32'h1234);

    // R8: write cut short by an MDC stall
    s0 = strobeCnt;
    doWrite(2'b01, LOCAL_ADDR, 5'd6, 16'hBEEF, 32, 10);
    chk("R8 truncated write ignored", strobeCnt - s0, 0);
    doWrite(2'b01, LOCAL_ADDR, 5'd6, 16'h0F0F, 32, 16);
    chk("R8 next frame served", strobeCnt - s0, 1);
    chk("R8 next frame data", lastData, 32'h0F0F);
    model[6] = 16'h0F0F;
    doRead(LOCAL_ADDR, 5'd6, rd, ta1Oe, ta2Oe, ta2Val, endOe);
    chk("R8 readback after recovery", rd, 32'h0F0F);

    // random mix against the shadow model
    for (int n = 0; n < 40; n++) begin
      logic [4:0]  phy;
      logic [4:0]  rg;
      logic [15:0] d;
      logic        isWr;
      int sel;
      sel  = int'($urandom % 3);
      rg   = 5'($urandom);
      d    = 16'($urandom);
      isWr = 1'($urandom);
      if (sel == 0)      phy = LOCAL_ADDR;
      else if (sel == 1) phy = 5'd0;
      else begin
        phy = 5'(1 + ($urandom % 31));
        if (phy == LOCAL_ADDR) phy = 5'd10;
      end
      s0 = strobeCnt; o0 = oeCycles;
      if (isWr) begin
        doWrite(2'b01, phy, rg, d, 32, 16);
        if (accepts(phy)) begin
          chk("R2 random write strobe", strobeCnt - s0, 1);
          chk("R2 random write data", lastData, {16'b0, d});
          model[rg] = d;
        end else begin
          chk("R5 random foreign write", strobeCnt - s0, 0);
        end
      end else begin
        doRead(phy, rg, rd, ta1Oe, ta2Oe, ta2Val, endOe);
        if (accepts(phy)) begin
          chk("R3 random read data", rd, {16'b0, model[rg]});
          chk("R9 random read release", {31'b0, endOe}, 32'd0);
        end else begin
          chk("R5 random foreign read", oeCycles - o0, 0);
        end
      end
    end

    $display("  %0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule